// File: doc/BRIEF.md
# Seconds/Nanoseconds Time-of-Day Counter

This block keeps the time of day for a precision time protocol clock. It holds a 32-bit seconds word and a 32-bit nanoseconds word. While enabled it advances them by a fixed nanosecond increment on every clock. The nanoseconds word wraps at a programmable limit, and each wrap carries one into the seconds word. A mode bit turns the pair into one plain 64-bit nanosecond count instead.

Software drives the block through a small register bus. It writes the count directly while the counter is stopped. It steps the reported time with a signed offset that leaves the running count untouched. It can also arm a hardware preload: a new time is held ready, loaded on the next rising edge of an external pulse, and a pending status shows when that load has happened. Time is read back from a separate pair of registers. Reading the low word captures the matching high word, so the two halves always belong to the same instant.

Top module: `tod_clock`

## Requirements
- R1: After reset the control register reads 0, the count and the reported time read 0, and the rollover register reads `ROLL_RST`.
- R2: Control bit 0 enables counting. While it is 1 the count advances by `INCR_NS` every clock. While it is 0 the count holds its value.
- R3: A bus write to register 1 replaces the nanoseconds count word, and a write to register 2 replaces the seconds count word. Both registers read back the raw count. The count does not advance in a cycle that carries such a write.
- R4: With control bit 1 at 0, the sum nanoseconds + `INCR_NS` is compared with register 3, the rollover value. When the sum exceeds it, nanoseconds becomes sum − rollover − 1 and seconds increments by one.
- R5: With control bit 1 at 1, {seconds, nanoseconds} is treated as one 64-bit count that increments by `INCR_NS`. It carries from the low word into the high word and never wraps at the rollover value.
- R6: The reported time equals the count plus a signed offset: register 4 holds the two's-complement nanosecond offset and register 5 the seconds offset. In normal mode the nanosecond sum is brought back into 0..rollover by adding or subtracting rollover + 1, and the seconds result is adjusted by +1 or −1 to match. In 64-bit mode the offset is added as one 64-bit value.
- R7: Writing control bit 2 as 1 while it was 0 arms the preload and sets control bit 14 (pending). Writing bit 2 as 0 clears pending. Registers 6 (nanoseconds) and 7 (seconds) hold the preload time.
- R8: On a clock in which `pps_in` is 1 after being 0 on the previous clock, and pending is set, the count is loaded with the preload time and pending returns to 0 in that same cycle. The count then advances from the loaded value.
- R9: A rising edge of `pps_in` while pending is 0 leaves the count unchanged. Holding `pps_in` high does not load a preload that is armed afterwards; only the next rising edge does.
- R10: A read of register 8 returns the reported nanoseconds and captures the reported seconds. A read of register 9 returns that captured value, however much time has passed since. Read data appears on `bus_rdata` one clock after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| pps_in | input | 1 | External pulse whose rising edge applies an armed preload |

## Verification
The hardest case to reach is the interaction between the edge-triggered preload and a level that is already high. The bench raises `pps_in` and holds it there, then disarms and re-arms the preload. It confirms that pending stays set and the count keeps running until the pulse falls and rises again. A small rollover value makes the seconds carry, the offset carry and the offset borrow happen within a few clocks. The bench also reads the high half many wraps after the low half, which exposes a capture that fails to hold.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        RG_CTRL    = 4'd0,
        RG_CNT_NS  = 4'd1,
        RG_CNT_S   = 4'd2,
        RG_ROLL    = 4'd3,
        RG_OFS_NS  = 4'd4,
        RG_OFS_S   = 4'd5,
        RG_PRE_NS  = 4'd6,
        RG_PRE_S   = 4'd7,
        RG_TIME_LO = 4'd8,
        RG_TIME_HI = 4'd9
    } reg_idx_e;

    localparam int CB_EN   = 0;
    localparam int CB_WIDE = 1;
    localparam int CB_ARM  = 2;
    localparam int CB_PEND = 14;

    typedef struct packed {
        word_t sec;
        word_t nsec;
    } tod_time_t;

    typedef struct packed {
        logic      en;
        logic      wide;
        logic      arm;
        word_t     roll;
        word_t     ofs_ns;
        word_t     ofs_s;
        tod_time_t pre;
    } tod_cfg_t;

    // Count plus signed offset, nanoseconds normalised into 0..roll
    function automatic tod_time_t apply_offset(tod_time_t t, word_t ofs_ns,
                                               word_t ofs_s, word_t roll,
                                               logic wide);
        logic signed [WORD_W+1:0] sum;
        logic signed [WORD_W+1:0] lim;
        word_t     carry;
        tod_time_t r;
        r = t;
        if (wide) begin
            r = tod_time_t'({t.sec, t.nsec} + {ofs_s, ofs_ns});
        end else begin
            lim   = $signed({2'b00, roll}) + $signed({{(WORD_W+1){1'b0}}, 1'b1});
            sum   = $signed({2'b00, t.nsec}) + $signed({{2{ofs_ns[WORD_W-1]}}, ofs_ns});
            carry = '0;
            if (sum >= lim) begin
                sum   = sum - lim;
                carry = word_t'(1);
            end else if (sum[WORD_W+1]) begin
                sum   = sum + lim;
                carry = '1;
            end
            r.nsec = sum[WORD_W-1:0];
            r.sec  = t.sec + ofs_s + carry;
        end
        return r;
    endfunction
endpackage

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs
    import tod_pkg::*;
#(
    parameter word_t ROLL_RST = word_t'(999_999_999)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output tod_cfg_t          cfg,
    output logic              wr_ns,
    output logic              wr_s,
    output logic              arm_set,
    output logic              arm_clr
);
    logic ctrl_wr;

    assign ctrl_wr = wr && (addr == RG_CTRL);
    assign wr_ns   = wr && (addr == RG_CNT_NS);
    assign wr_s    = wr && (addr == RG_CNT_S);
    assign arm_set = ctrl_wr && wdata[CB_ARM] && !cfg.arm;
    assign arm_clr = ctrl_wr && !wdata[CB_ARM];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cfg.roll <= ROLL_RST;
        end else if (wr) begin
            case (addr)
                RG_CTRL: begin
                    cfg.en   <= wdata[CB_EN];
                    cfg.wide <= wdata[CB_WIDE];
                    cfg.arm  <= wdata[CB_ARM];
                end
                RG_ROLL:   cfg.roll     <= wdata;
                RG_OFS_NS: cfg.ofs_ns   <= wdata;
                RG_OFS_S:  cfg.ofs_s    <= wdata;
                RG_PRE_NS: cfg.pre.nsec <= wdata;
                RG_PRE_S:  cfg.pre.sec  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tod_core.sv
`timescale 1ns/1ps
module tod_core
    import tod_pkg::*;
#(
    parameter int unsigned INCR_NS = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      wide,
    input  word_t     roll,
    input  tod_time_t pre,
    input  logic      wr_ns,
    input  logic      wr_s,
    input  word_t     wdata,
    input  logic      arm_set,
    input  logic      arm_clr,
    input  logic      pps_in,
    output tod_time_t cnt,
    output logic      pend
);
    localparam logic [WORD_W:0]     INC_N = (WORD_W+1)'(INCR_NS);
    localparam logic [2*WORD_W-1:0] INC_W = (2*WORD_W)'(INCR_NS);

    logic            pps_q;
    logic            pps_edge;
    logic            load;
    logic [WORD_W:0] bump;
    tod_time_t       nxt;

    assign pps_edge = pps_in && !pps_q;
    assign load     = pps_edge && pend;

    always_comb begin
        bump = {1'b0, cnt.nsec} + INC_N;
        nxt  = cnt;
        if (wide) begin
            nxt = tod_time_t'(cnt + INC_W);
        end else if (bump > {1'b0, roll}) begin
            nxt.nsec = word_t'(bump - {1'b0, roll} - 1'b1);
            nxt.sec  = cnt.sec + 1'b1;
        end else begin
            nxt.nsec = bump[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pend  <= 1'b0;
            pps_q <= 1'b0;
        end else begin
            pps_q <= pps_in;
            if (load) begin
                cnt  <= pre;
                pend <= 1'b0;
            end else begin
                if (wr_ns) cnt.nsec <= wdata;
                if (wr_s)  cnt.sec  <= wdata;
                if (!wr_ns && !wr_s && en) cnt <= nxt;
                if (arm_set) pend <= 1'b1;
                if (arm_clr) pend <= 1'b0;
            end
        end
    end

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_ns && !wr_s && !load) |=> $stable(cnt));

    // R4
    ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!wide && en && !wr_ns && !wr_s && !load && cnt.nsec <= roll &&
         {1'b0, roll} >= INC_N) |=> (cnt.nsec <= $past(roll)));

    // R4
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !wr_ns && !wr_s && !load) |=>
        (cnt.sec == $past(cnt.sec) || cnt.sec == $past(cnt.sec) + 32'd1));

    // R8
    pend_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> ($past(pps_edge) || $past(arm_clr)));

    // R8
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(pre)));
endmodule

// File: rtl/tod_view.sv
`timescale 1ns/1ps
module tod_view
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  tod_cfg_t          cfg,
    input  tod_time_t         cnt,
    input  logic              pend,
    output word_t             rdata
);
    tod_time_t rep;
    word_t     shadow;
    word_t     ctrl_word;

    assign rep = apply_offset(cnt, cfg.ofs_ns, cfg.ofs_s, cfg.roll, cfg.wide);

    always_comb begin
        ctrl_word          = '0;
        ctrl_word[CB_EN]   = cfg.en;
        ctrl_word[CB_WIDE] = cfg.wide;
        ctrl_word[CB_ARM]  = cfg.arm;
        ctrl_word[CB_PEND] = pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            shadow <= '0;
        end else if (rd) begin
            case (addr)
                RG_CTRL:   rdata <= ctrl_word;
                RG_CNT_NS: rdata <= cnt.nsec;
                RG_CNT_S:  rdata <= cnt.sec;
                RG_ROLL:   rdata <= cfg.roll;
                RG_OFS_NS: rdata <= cfg.ofs_ns;
                RG_OFS_S:  rdata <= cfg.ofs_s;
                RG_PRE_NS: rdata <= cfg.pre.nsec;
                RG_PRE_S:  rdata <= cfg.pre.sec;
                RG_TIME_LO: begin
                    rdata  <= rep.nsec;
                    shadow <= rep.sec;
                end
                RG_TIME_HI: rdata <= shadow;
                default:    rdata <= '0;
            endcase
        end
    end

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd && addr == RG_TIME_LO) |=> $stable(shadow));

    // R10
    hi_from_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == RG_TIME_HI) |=> (rdata == $past(shadow)));
endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
    import tod_pkg::*;
#(
    parameter int unsigned INCR_NS  = 20,
    parameter word_t       ROLL_RST = word_t'(999_999_999)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              pps_in
);
    tod_cfg_t  cfg;
    tod_time_t cnt;
    logic      wr_ns, wr_s, arm_set, arm_clr, pend;

    tod_regs #(.ROLL_RST(ROLL_RST)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cfg(cfg), .wr_ns(wr_ns), .wr_s(wr_s), .arm_set(arm_set), .arm_clr(arm_clr)
    );

    tod_core #(.INCR_NS(INCR_NS)) u_core (
        .clk(clk), .rst(rst), .en(cfg.en), .wide(cfg.wide), .roll(cfg.roll),
        .pre(cfg.pre), .wr_ns(wr_ns), .wr_s(wr_s), .wdata(bus_wdata),
        .arm_set(arm_set), .arm_clr(arm_clr), .pps_in(pps_in),
        .cnt(cnt), .pend(pend)
    );

    tod_view u_view (
        .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .cfg(cfg),
        .cnt(cnt), .pend(pend), .rdata(bus_rdata)
    );
endmodule

// File: tb/test_tod_clock.sv
`timescale 1ns/1ps
module test_tod_clock;
    localparam int unsigned INCR = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pps_in = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    tod_clock i_tod_clock (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pps_in(pps_in)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    longint      m_s, m_ns, m_roll;
    bit          m_en, m_wide, m_arm, m_pend, m_pps_q;
    logic [31:0] m_ofs_ns, m_ofs_s, m_pre_ns, m_pre_s, m_shadow, m_rdata;

    function automatic logic [63:0] m_report();
        logic [63:0] v;
        longint sum, c, hi;
        if (m_wide) begin
            v = {m_s[31:0], m_ns[31:0]} + {m_ofs_s, m_ofs_ns};
        end else begin
            sum = m_ns + longint'($signed(m_ofs_ns));
            c = 0;
            if (sum > m_roll) begin sum = sum - (m_roll + 1); c = 1; end
            else if (sum < 0) begin sum = sum + (m_roll + 1); c = -1; end
            hi = m_s + longint'($signed(m_ofs_s)) + c;
            v = {hi[31:0], sum[31:0]};
        end
        return v;
    endfunction

    always @(posedge clk) begin
        logic [63:0] rp;
        logic [63:0] w;
        bit edge_seen, loaded;
        if (rst) begin
            m_s = 0; m_ns = 0; m_roll = 999999999;
            m_en = 0; m_wide = 0; m_arm = 0; m_pend = 0; m_pps_q = 0;
            m_ofs_ns = 0; m_ofs_s = 0; m_pre_ns = 0; m_pre_s = 0;
            m_shadow = 0; m_rdata = 0;
        end else begin
            rp = m_report();
            if (bus_rd) begin
                case (bus_addr)
                    4'd0: m_rdata = {17'b0, m_pend, 11'b0, m_arm, m_wide, m_en};
                    4'd1: m_rdata = m_ns[31:0];
                    4'd2: m_rdata = m_s[31:0];
                    4'd3: m_rdata = m_roll[31:0];
                    4'd4: m_rdata = m_ofs_ns;
                    4'd5: m_rdata = m_ofs_s;
                    4'd6: m_rdata = m_pre_ns;
                    4'd7: m_rdata = m_pre_s;
                    4'd8: begin m_rdata = rp[31:0]; m_shadow = rp[63:32]; end
                    4'd9: m_rdata = m_shadow;
                    default: m_rdata = 0;
                endcase
            end
            edge_seen = pps_in && !m_pps_q;
            m_pps_q = pps_in;
            loaded = edge_seen && m_pend;
            if (loaded) begin
                m_s = m_pre_s; m_ns = m_pre_ns; m_pend = 0;
            end else if (bus_wr && bus_addr == 4'd1) begin
                m_ns = bus_wdata;
            end else if (bus_wr && bus_addr == 4'd2) begin
                m_s = bus_wdata;
            end else if (m_en) begin
                if (m_wide) begin
                    w = {m_s[31:0], m_ns[31:0]} + 64'(INCR);
                    m_s = w[63:32]; m_ns = w[31:0];
                end else begin
                    m_ns = m_ns + INCR;
                    if (m_ns > m_roll) begin
                        m_ns = m_ns - (m_roll + 1);
                        m_s = (m_s + 1) & 64'hFFFF_FFFF;
                    end
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: begin
                        if (!loaded) begin
                            if (bus_wdata[2] && !m_arm) m_pend = 1;
                            if (!bus_wdata[2]) m_pend = 0;
                        end
                        m_en = bus_wdata[0]; m_wide = bus_wdata[1]; m_arm = bus_wdata[2];
                    end
                    4'd3: m_roll = bus_wdata;
                    4'd4: m_ofs_ns = bus_wdata;
                    4'd5: m_ofs_s = bus_wdata;
                    4'd6: m_pre_ns = bus_wdata;
                    4'd7: m_pre_s = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic do_read(input logic [3:0] a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, m_rdata);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_pps(input logic v);
        @(negedge clk);
        pps_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        idle(5);
        rst = 1'b0;
        // R1 reset state
        do_read(4'd0, "R1 ctrl after reset");
        do_read(4'd3, "R1 rollover after reset");
        do_read(4'd8, "R1 time lo after reset");
        do_read(4'd9, "R1 time hi after reset");
        // R3 direct write while stopped
        do_write(4'd3, 32'd99);
        do_write(4'd1, 32'd40);
        do_write(4'd2, 32'd7);
        do_read(4'd1, "R3 raw ns");
        do_read(4'd2, "R3 raw sec");
        idle(4);
        do_read(4'd8, "R2 holds while disabled");
        // R2 / R4 counting with small rollover
        do_write(4'd0, 32'h1);
        idle(2);
        do_read(4'd8, "R2 advancing ns");
        do_read(4'd9, "R4 sec after carry");
        for (int i = 0; i < 5; i++) begin
            idle(i + 1);
            do_read(4'd8, "R4 wrap ns");
            do_read(4'd9, "R4 wrap sec");
        end
        // R10 shadow holds across many wraps
        do_read(4'd8, "R10 lo snapshot");
        idle(17);
        do_read(4'd2, "R10 live sec moved");
        do_read(4'd9, "R10 hi from snapshot");
        // R6 offsets
        do_write(4'd4, 32'd70);
        for (int i = 0; i < 5; i++) begin
            do_read(4'd8, "R6 carry lo");
            do_read(4'd9, "R6 carry hi");
        end
        do_write(4'd4, 32'hFFFF_FFA6);
        do_write(4'd5, 32'd3);
        for (int i = 0; i < 4; i++) begin
            do_read(4'd8, "R6 borrow lo");
            do_read(4'd9, "R6 borrow hi");
        end
        do_write(4'd4, 32'd0);
        do_write(4'd5, 32'd0);
        // R7 / R8 preload
        do_write(4'd7, 32'd100);
        do_write(4'd6, 32'd0);
        do_write(4'd0, 32'h5);
        do_read(4'd0, "R7 pending set");
        do_read(4'd7, "R7 preload sec readback");
        set_pps(1'b1);
        idle(1);
        do_read(4'd0, "R8 pending cleared");
        do_read(4'd8, "R8 loaded lo");
        do_read(4'd9, "R8 loaded hi");
        // R9 level high does not reload a fresh arm
        do_write(4'd7, 32'd200);
        do_write(4'd0, 32'h1);
        do_write(4'd0, 32'h5);
        idle(3);
        do_read(4'd0, "R9 still pending under high level");
        do_read(4'd2, "R9 sec not reloaded");
        set_pps(1'b0);
        idle(1);
        set_pps(1'b1);
        idle(1);
        do_read(4'd0, "R8 second edge clears pending");
        do_read(4'd2, "R8 second edge loads sec");
        // R9 edge without arm
        do_write(4'd0, 32'h1);
        do_write(4'd7, 32'd500);
        set_pps(1'b0);
        idle(1);
        set_pps(1'b1);
        idle(2);
        do_read(4'd2, "R9 unarmed edge ignored");
        do_read(4'd0, "R9 ctrl no pending");
        // R5 64-bit mode
        do_write(4'd0, 32'h0);
        do_write(4'd1, 32'hFFFF_FF00);
        do_write(4'd2, 32'd3);
        do_write(4'd0, 32'h3);
        idle(20);
        do_read(4'd1, "R5 low word past 2^32");
        do_read(4'd2, "R5 high word carry");
        do_read(4'd8, "R5 reported lo");
        do_read(4'd9, "R5 reported hi");
        idle(2);
        report();
    end
endmodule